// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a decoded operand-addressing byte, up to two displacement bytes and the current values of the four address registers (BX, BP, SI, DI) into a 16-bit effective address and a 2-bit segment code. The addressing byte holds a 2-bit mode field in bits 7:6, a 3-bit middle field in bits 5:3 that this unit ignores, and a 3-bit selector field in bits 2:0. When the mode names a register operand, the unit forms no address. It reports a register-operand flag and a 4-bit register number instead.

The result is computed combinationally and captured in output registers on the rising clock edge where `calc_strobe` is high. It then holds until the next strobe. A valid segment override replaces the default segment. The unit does not add a segment base, does not access memory and does not decode instructions.

Top module: `addr_form_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs are cleared to `eff_addr`=0, `seg_code`=3 (DS), `reg_operand`=0 and `reg_index`=0.
- R2: The outputs load on each rising edge where `calc_strobe` is high and keep their values on every edge where it is low, whatever the other inputs do.
- R3: For selector values 000, 001, 010 and 011, the address sums two registers plus the displacement: BX+SI, BX+DI, BP+SI and BP+DI respectively.
- R4: For selector values 100, 101 and 111, the address is SI, DI or BX plus the displacement. Selector 110 gives BP plus the displacement when the mode is 01 or 10.
- R5: When mode=00 and selector=110, the address is {`disp_hi`,`disp_lo`} and no register is used.
- R6: The displacement is zero for mode 00. For mode 01 it is `disp_lo` sign-extended to 16 bits. For mode 10 it is {`disp_hi`,`disp_lo`}.
- R7: All address sums wrap modulo 2^16.
- R8: Mode 11 gives `reg_operand`=1, `reg_index`={`wide`,selector} and `eff_addr`=0. Any memory mode gives `reg_operand`=0 and `reg_index`=0.
- R9: With no override, the segment code is 2 (SS) for addresses whose base is BP (selectors 010 and 011, and 110 outside the direct case). Every other case gives 3 (DS), including the direct case and mode 11.
- R10: When `seg_ovr_valid` is 1, `seg_code` equals `seg_ovr_code` in every mode. The segment codes are 0=ES, 1=CS, 2=SS and 3=DS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| calc_strobe | input | 1 | Capture the computed result on this edge |
| modrm | input | 8 | Addressing byte: mode [7:6], unused [5:3], selector [2:0] |
| wide | input | 1 | Operand width bit, 1 = word |
| disp_lo | input | 8 | Low displacement byte |
| disp_hi | input | 8 | High displacement byte |
| bx_val | input | 16 | BX contents |
| bp_val | input | 16 | BP contents |
| si_val | input | 16 | SI contents |
| di_val | input | 16 | DI contents |
| seg_ovr_valid | input | 1 | Override prefix present |
| seg_ovr_code | input | 2 | Override segment code |
| eff_addr | output | 16 | Effective address |
| seg_code | output | 2 | Selected segment code |
| reg_operand | output | 1 | Operand is a register |
| reg_index | output | 4 | {wide, selector} when the operand is a register |

## Verification
Default-segment selection and override replacement act in the same cycle. The bench provokes this by applying an override to a BP-based address, to the direct-address case and to a register operand. In each case it expects the override code, never the SS/DS default. Sign extension and modulo wrap also fall in one sum: a negative byte displacement added to a small base, and register values near 0xFFFF, are compared against a bench model written from the requirements.

// File: rtl/eau_pkg.sv
// Package eau_pkg: segment codes and field constants shared by the
// effective address unit. Assumes the 2-bit mode / 3-bit selector layout.
package eau_pkg;
    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_BYTE   = 2'b01;
    localparam logic [1:0] MODE_WORD   = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;
    localparam logic [2:0] SEL_DIRECT  = 3'b110;
endpackage

// File: rtl/eau_disp_ext.sv
// eau_disp_ext: forms the displacement from the mode field.
// Assumes AW is twice the byte width; mode 11 is treated as zero.
module eau_disp_ext
    import eau_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [1:0]      mode,
    input  logic [AW/2-1:0] dlo,
    input  logic [AW/2-1:0] dhi,
    output logic [AW-1:0]   disp
);
    localparam int BW = AW / 2;

    // choose zero, sign-extended byte or full word displacement
    always_comb begin
        unique case (mode)
            MODE_BYTE: disp = {{(AW - BW){dlo[BW-1]}}, dlo};
            MODE_WORD: disp = {dhi, dlo};
            default:   disp = '0;
        endcase
    end
endmodule

// File: rtl/eau_base_index.sv
// eau_base_index: adds base, index and displacement per the selector.
// Flags BP-based addressing for segment defaulting; sums wrap at AW bits.
module eau_base_index
    import eau_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [1:0]    mode,
    input  logic [2:0]    sel,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] direct_word,
    input  logic [AW-1:0] bx,
    input  logic [AW-1:0] bp,
    input  logic [AW-1:0] si,
    input  logic [AW-1:0] di,
    output logic [AW-1:0] sum,
    output logic          bp_based
);
    logic [AW-1:0] base_v;
    logic [AW-1:0] index_v;
    logic          is_direct;

    // detect the no-register direct address case
    assign is_direct = (mode == MODE_NODISP) && (sel == SEL_DIRECT);

    // pick base and index operands for the selector
    always_comb begin
        base_v   = '0;
        index_v  = '0;
        bp_based = 1'b0;
        unique case (sel)
            3'b000: begin base_v = bx; index_v = si; end
            3'b001: begin base_v = bx; index_v = di; end
            3'b010: begin base_v = bp; index_v = si; bp_based = 1'b1; end
            3'b011: begin base_v = bp; index_v = di; bp_based = 1'b1; end
            3'b100: index_v = si;
            3'b101: index_v = di;
            3'b110: begin base_v = bp; bp_based = !is_direct; end
            default: base_v = bx;
        endcase
    end

    // three-input modulo sum, or the direct word
    always_comb begin
        if (is_direct) sum = direct_word;
        else           sum = base_v + index_v + disp;
    end
endmodule

// File: rtl/eau_seg_pick.sv
// eau_seg_pick: default segment selection with override replacement.
// Assumes bp_based is already cleared for direct and register operands.
module eau_seg_pick
    import eau_pkg::*;
(
    input  logic       bp_based,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_code,
    output logic [1:0] seg
);
    // override wins, else SS for BP-based, else DS
    always_comb begin
        if (ovr_valid)     seg = ovr_code;
        else if (bp_based) seg = SEG_SS;
        else               seg = SEG_DS;
    end
endmodule

// File: rtl/addr_form_unit.sv
// addr_form_unit: effective address generation with registered outputs.
// Captures on calc_strobe and holds otherwise; synchronous active-low reset.
module addr_form_unit
    import eau_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            calc_strobe,
    input  logic [7:0]      modrm,
    input  logic            wide,
    input  logic [AW/2-1:0] disp_lo,
    input  logic [AW/2-1:0] disp_hi,
    input  logic [AW-1:0]   bx_val,
    input  logic [AW-1:0]   bp_val,
    input  logic [AW-1:0]   si_val,
    input  logic [AW-1:0]   di_val,
    input  logic            seg_ovr_valid,
    input  logic [1:0]      seg_ovr_code,
    output logic [AW-1:0]   eff_addr,
    output logic [1:0]      seg_code,
    output logic            reg_operand,
    output logic [3:0]      reg_index
);
    logic [1:0]    mode;
    logic [2:0]    sel;
    logic [AW-1:0] disp_w;
    logic [AW-1:0] sum_w;
    logic          bp_w;
    logic          bp_mem;
    logic          is_reg;
    logic [1:0]    seg_w;

    assign mode   = modrm[7:6];
    assign sel    = modrm[2:0];
    assign is_reg = (mode == MODE_REG);
    assign bp_mem = bp_w && !is_reg;

    eau_disp_ext #(.AW(AW)) u_disp (
        .mode (mode),
        .dlo  (disp_lo),
        .dhi  (disp_hi),
        .disp (disp_w)
    );

    eau_base_index #(.AW(AW)) u_sum (
        .mode        (mode),
        .sel         (sel),
        .disp        (disp_w),
        .direct_word ({disp_hi, disp_lo}),
        .bx          (bx_val),
        .bp          (bp_val),
        .si          (si_val),
        .di          (di_val),
        .sum         (sum_w),
        .bp_based    (bp_w)
    );

    eau_seg_pick u_seg (
        .bp_based  (bp_mem),
        .ovr_valid (seg_ovr_valid),
        .ovr_code  (seg_ovr_code),
        .seg       (seg_w)
    );

    // output register: reset, capture on strobe, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_addr    <= '0;
            seg_code    <= SEG_DS;
            reg_operand <= 1'b0;
            reg_index   <= '0;
        end else if (calc_strobe) begin
            eff_addr    <= is_reg ? '0 : sum_w;
            seg_code    <= seg_w;
            reg_operand <= is_reg;
            reg_index   <= is_reg ? {wide, sel} : 4'd0;
        end
    end
endmodule

// File: rtl/eau_checks.sv
// eau_checks: temporal properties of addr_form_unit, attached by bind.
// Assumes outputs follow a strobe by one edge.
module eau_checks #(
    parameter int AW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            calc_strobe,
    input logic [7:0]      modrm,
    input logic            wide,
    input logic [AW/2-1:0] disp_lo,
    input logic [AW/2-1:0] disp_hi,
    input logic [AW-1:0]   si_val,
    input logic            seg_ovr_valid,
    input logic [1:0]      seg_ovr_code,
    input logic [AW-1:0]   eff_addr,
    input logic [1:0]      seg_code,
    input logic            reg_operand,
    input logic [3:0]      reg_index
);
    logic [AW-1:0] sext_lo;
    logic          bp_sel;
    assign sext_lo = {{(AW/2){disp_lo[AW/2-1]}}, disp_lo};
    assign bp_sel  = (modrm[2:1] == 2'b01) ||
                     (modrm[2:0] == 3'b110 && modrm[7:6] != 2'b00);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_strobe |=> $stable(eff_addr) && $stable(seg_code)
                         && $stable(reg_operand) && $stable(reg_index));

    // R8
    reg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_strobe && modrm[7:6] == 2'b11 |=>
            reg_operand && eff_addr == '0 && reg_index == {$past(wide), $past(modrm[2:0])});

    // R8
    mem_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_strobe && modrm[7:6] != 2'b11 |=> !reg_operand && reg_index == 4'd0);

    // R5
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_strobe && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110 |=>
            eff_addr == {$past(disp_hi), $past(disp_lo)});

    // R6
    byte_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_strobe && modrm[7:6] == 2'b01 && modrm[2:0] == 3'b100 |=>
            eff_addr == $past(si_val + sext_lo));

    // R10
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_strobe && seg_ovr_valid |=> seg_code == $past(seg_ovr_code));

    // R9
    default_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_strobe && !seg_ovr_valid && modrm[7:6] != 2'b11 |=>
            seg_code == ($past(bp_sel) ? 2'd2 : 2'd3));
endmodule

bind addr_form_unit eau_checks #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .calc_strobe   (calc_strobe),
    .modrm         (modrm),
    .wide          (wide),
    .disp_lo       (disp_lo),
    .disp_hi       (disp_hi),
    .si_val        (si_val),
    .seg_ovr_valid (seg_ovr_valid),
    .seg_ovr_code  (seg_ovr_code),
    .eff_addr      (eff_addr),
    .seg_code      (seg_code),
    .reg_operand   (reg_operand),
    .reg_index     (reg_index)
);

// File: tb/sim_addr_form_unit.sv
// sim_addr_form_unit: vector table, then directed reset, hold, wrap and random checks.
module sim_addr_form_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        calc_strobe = 1'b0;
    logic [7:0]  modrm = '0;
    logic        wide = 1'b0;
    logic [7:0]  disp_lo = '0;
    logic [7:0]  disp_hi = '0;
    logic [15:0] bx_val = 16'h1000;
    logic [15:0] bp_val = 16'h2000;
    logic [15:0] si_val = 16'h0030;
    logic [15:0] di_val = 16'h0004;
    logic        seg_ovr_valid = 1'b0;
    logic [1:0]  seg_ovr_code = '0;
    logic [15:0] eff_addr;
    logic [1:0]  seg_code;
    logic        reg_operand;
    logic [3:0]  reg_index;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addr_form_unit u0 (.*);

    typedef struct packed {
        logic [7:0]  m;
        logic        w;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic        ov;
        logic [1:0]  ovs;
        logic [15:0] ea;
        logic [1:0]  seg;
        logic        isr;
        logic [3:0]  ri;
        logic [3:0]  req;
    } vec_t;

    // BX=1000 BP=2000 SI=0030 DI=0004 for every row
    localparam logic [54:0] TBL [0:12] = '{
        {8'b00_000_000,1'b0,8'h00,8'h00,1'b0,2'd0,16'h1030,2'd3,1'b0,4'd0,4'd3},    // R3
        {8'b01_000_001,1'b0,8'hF0,8'h00,1'b0,2'd0,16'h0FF4,2'd3,1'b0,4'd0,4'd6},    // R6
        {8'b10_000_010,1'b0,8'h34,8'h12,1'b0,2'd0,16'h3264,2'd2,1'b0,4'd0,4'd3},    // R3
        {8'b00_000_011,1'b0,8'h55,8'h66,1'b0,2'd0,16'h2004,2'd2,1'b0,4'd0,4'd9},    // R9
        {8'b10_000_100,1'b0,8'h00,8'h01,1'b0,2'd0,16'h0130,2'd3,1'b0,4'd0,4'd4},    // R4
        {8'b01_000_101,1'b0,8'h7F,8'h00,1'b0,2'd0,16'h0083,2'd3,1'b0,4'd0,4'd6},    // R6
        {8'b01_000_110,1'b0,8'h80,8'h00,1'b0,2'd0,16'h1F80,2'd2,1'b0,4'd0,4'd4},    // R4
        {8'b00_000_111,1'b0,8'h99,8'h99,1'b0,2'd0,16'h1000,2'd3,1'b0,4'd0,4'd4},    // R4
        {8'b00_000_110,1'b0,8'hCD,8'hAB,1'b0,2'd0,16'hABCD,2'd3,1'b0,4'd0,4'd5},    // R5
        {8'b00_000_110,1'b0,8'hCD,8'hAB,1'b1,2'd0,16'hABCD,2'd0,1'b0,4'd0,4'd10},   // R10
        {8'b00_000_010,1'b0,8'h00,8'h00,1'b1,2'd1,16'h2030,2'd1,1'b0,4'd0,4'd10},   // R10
        {8'b11_000_011,1'b1,8'h12,8'h34,1'b0,2'd0,16'h0000,2'd3,1'b1,4'b1011,4'd8}, // R8
        {8'b11_000_100,1'b0,8'h12,8'h34,1'b1,2'd2,16'h0000,2'd2,1'b1,4'b0100,4'd8}  // R8
    };

    task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ea/seg/reg/idx actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] m, input logic w, input logic [7:0] lo,
                         input logic [7:0] hi, input logic ov, input logic [1:0] ovs);
        @(negedge clk);
        modrm = m; wide = w; disp_lo = lo; disp_hi = hi;
        seg_ovr_valid = ov; seg_ovr_code = ovs; calc_strobe = 1'b1;
        @(negedge clk);
        calc_strobe = 1'b0;
    endtask

    function automatic logic [22:0] model(input logic [7:0] m, input logic w,
                                          input logic [7:0] lo, input logic [7:0] hi,
                                          input logic ov, input logic [1:0] ovs);
        logic [15:0] d, a;
        logic [1:0] s;
        s = 2'd3;
        d = (m[7:6] == 2'b01) ? {{8{lo[7]}}, lo} : (m[7:6] == 2'b10) ? {hi, lo} : 16'h0;
        case (m[2:0])
            3'd0: a = bx_val + si_val + d;
            3'd1: a = bx_val + di_val + d;
            3'd2: begin a = bp_val + si_val + d; s = 2'd2; end
            3'd3: begin a = bp_val + di_val + d; s = 2'd2; end
            3'd4: a = si_val + d;
            3'd5: a = di_val + d;
            3'd6: if (m[7:6] == 2'b00) a = {hi, lo};
                  else begin a = bp_val + d; s = 2'd2; end
            default: a = bx_val + d;
        endcase
        if (m[7:6] == 2'b11) begin
            s = 2'd3;
            if (ov) s = ovs;
            return {16'h0, s, 1'b1, w, m[2:0]};
        end
        if (ov) s = ovs;
        return {a, s, 1'b0, 4'd0};
    endfunction

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {eff_addr, seg_code, reg_operand, reg_index}, {16'h0, 2'd3, 1'b0, 4'd0});
        rst_n = 1'b1;

        for (int i = 0; i < 13; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            apply(v.m, v.w, v.lo, v.hi, v.ov, v.ovs);
            check($sformatf("R%0d row %0d", v.req, i),
                  {eff_addr, seg_code, reg_operand, reg_index}, {v.ea, v.seg, v.isr, v.ri});
        end

        // R2 hold: change every input without strobe
        @(negedge clk);
        modrm = 8'b10_000_000; disp_lo = 8'hFF; disp_hi = 8'hFF; wide = 1'b0;
        seg_ovr_valid = 1'b1; seg_ovr_code = 2'd0; bx_val = 16'h7777;
        repeat (3) @(negedge clk);
        check("R2 hold", {eff_addr, seg_code, reg_operand, reg_index}, {16'h0, 2'd2, 1'b1, 4'b0100});

        // R7 wrap around 0xFFFF
        bx_val = 16'hFFFF; si_val = 16'h0002;
        apply(8'b10_000_000, 1'b0, 8'h01, 8'h00, 1'b0, 2'd0);
        check("R7 wrap", {eff_addr, seg_code, reg_operand, reg_index}, {16'h0002, 2'd3, 1'b0, 4'd0});
        bp_val = 16'hFFF0; di_val = 16'h0020;
        apply(8'b01_000_011, 1'b0, 8'hF0, 8'h00, 1'b0, 2'd0);
        check("R7 wrap neg", {eff_addr, seg_code, reg_operand, reg_index}, {16'h0000, 2'd2, 1'b0, 4'd0});

        // R10 override on BP-based default
        apply(8'b10_000_110, 1'b0, 8'h00, 8'h00, 1'b1, 2'd3);
        check("R10 bp override", {eff_addr, seg_code, reg_operand, reg_index}, {16'hFFF0, 2'd3, 1'b0, 4'd0});

        // R1 reset mid-run after a nonzero result
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", {eff_addr, seg_code, reg_operand, reg_index}, {16'h0, 2'd3, 1'b0, 4'd0});
        rst_n = 1'b1;

        // R3 R4 R6 R7 R9 random against model
        for (int k = 0; k < 300; k++) begin
            logic [7:0] m, lo, hi;
            logic w, ov;
            logic [1:0] ovs;
            bx_val = 16'($urandom); bp_val = 16'($urandom);
            si_val = 16'($urandom); di_val = 16'($urandom);
            m = 8'($urandom); lo = 8'($urandom); hi = 8'($urandom);
            w = 1'($urandom); ov = ($urandom % 4) == 0; ovs = 2'($urandom);
            apply(m, w, lo, hi, ov, ovs);
            check($sformatf("R3 R4 R6 R9 random %0d", k),
                  {eff_addr, seg_code, reg_operand, reg_index}, model(m, w, lo, hi, ov, ovs));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule